// File: doc/BRIEF.md
# I2C Target Status Flag Register

This block keeps the status and interrupt flags of one I2C target (slave) channel. A separate bus engine decodes the wire and reports single-cycle event strobes. These strobes cover: an address match after a START or after a repeated START, together with the index of the address slot that matched; a STOP; a general call and its kind; a master read that finds no data; and the receive and transmit FIFO conditions. Each flag is sticky. Each one is cleared by its own trigger: a status read, a receive-data read, a receive flush, a transmit-data write, two transmit-data writes, a STOP, a general-call reset, or a software clear strobe for the general-call record.

Software reads the 32-bit status word through a strobe. The word is captured into a holding register on the read cycle. The read also clears the read-sensitive flags that were set at that moment. A registered interrupt line is the OR of the flags that ask for service. The bus shifter, the address comparators and the FIFO storage are outside this block.

Top module: `i2c_tgt_status`

## Requirements
- R1: The status word is 32 bits wide, and bits 31..15 always read as zero. After synchronous reset `rst`, the word and `sts_rdata` are 0x0000_0001 and `irq` is 0.
- R2: When `sts_rd` is high in a cycle, `sts_rdata` shows, from the next cycle on, the word as it stood before that clock edge. Without `sts_rd`, `sts_rdata` holds its value.
- R3: Bit 14 is set by `ev_start_match` and bit 13 by `ev_rstart_match`. Both are cleared by `ev_stop`, by a status read, or by a general-call reset.
- R4: Bits 12..11 take the value of `ev_match_idx` (0..3) on either match strobe. A general-call reset returns them to 0.
- R5: Bit 10 is set by `ev_stop` when a match strobe has arrived since the last STOP or general-call reset. A STOP with no match before it leaves bit 10 unchanged. A status read clears bit 10.
- R6: A general call (`ev_gc`) sets bit 7 and loads bits 9..8 with `ev_gc_kind`. The codes are 01 = reset and program address, 10 = program address, 11 = alternative-ID match. These three bits clear only on `cfg_gc_clr`. A general call of kind 01 returns bits 14..10, 5..1 and 12..11 to 0 and sets bit 0.
- R7: Bit 6 equals `eng_busy` delayed by one clock cycle.
- R8: Bit 5 is set by `ev_rd_nodata` and is cleared by a status read.
- R9: Bit 4 (receive overflow) is cleared only by `rx_data_rd`. Bit 3 (byte received) is cleared by `rx_data_rd` or `rx_flush`.
- R10: Bit 2 (transmit done) and bit 1 (transmit underflow) are cleared by `tx_data_wr`.
- R11: Bit 0 is set by `ev_tx_empty` and by reset. It clears on the second `tx_data_wr` counted since it was last set. A new set restarts that count.
- R12: When a set and a clear for the same flag come in the same cycle, the flag ends up set. A status read clears only the flags that were set before the read edge.
- R13: `irq` is registered and equals the OR of bits 10, 7, 5, 4, 3, 2 and 1 of the word in the same cycle. Bits 14, 13, 6 and 0 do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start_match | input | 1 | START followed by a matching address |
| ev_rstart_match | input | 1 | Repeated START followed by a matching address |
| ev_match_idx | input | 2 | Index of the matching address slot |
| ev_stop | input | 1 | STOP condition seen |
| ev_gc | input | 1 | General call received |
| ev_gc_kind | input | 2 | General-call kind code (01, 10, 11) |
| cfg_gc_clr | input | 1 | Software clear of the general-call record |
| eng_busy | input | 1 | Bus engine busy level |
| ev_rd_nodata | input | 1 | Master read found no transmit data |
| ev_rx_ovf | input | 1 | Receive FIFO overflow |
| ev_rx_byte | input | 1 | Byte received |
| rx_data_rd | input | 1 | Software read of the receive data register |
| rx_flush | input | 1 | Receive FIFO flush |
| ev_tx_done | input | 1 | Transmission finished |
| ev_tx_udf | input | 1 | Transmit FIFO underflow |
| ev_tx_empty | input | 1 | Transmit FIFO became empty |
| tx_data_wr | input | 1 | Software write of the transmit data register |
| sts_rd | input | 1 | Status read strobe |
| sts_rdata | output | 32 | Captured status word |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 32-bit word and a two-write clear for the transmit-empty flag. With these values every field position that software decodes can be reached. The first write of the pair leaves bit 0 set, which shows that the count is not one. A table of single-cycle event vectors walks each flag through its set and clear triggers. Directed cases then cover a set and a clear in the same cycle, a STOP with no match before it, the defaults after a general-call reset, and a restart of the transmit-empty count after a partial write pair.

// File: rtl/i2c_tgt_status_pkg.sv
package i2c_tgt_status_pkg;

  // Field positions of the status word; software decodes these.
  localparam int unsigned B_START  = 14;
  localparam int unsigned B_RSTART = 13;
  localparam int unsigned B_IDX_LO = 11;
  localparam int unsigned IDX_W    = 2;
  localparam int unsigned B_STOPI  = 10;
  localparam int unsigned B_GC_LO  = 8;
  localparam int unsigned GC_W     = 2;
  localparam int unsigned B_GC_ANY = 7;
  localparam int unsigned B_BUSY   = 6;
  localparam int unsigned B_NODATA = 5;
  localparam int unsigned B_OVF    = 4;
  localparam int unsigned B_RXB    = 3;
  localparam int unsigned B_TXD    = 2;
  localparam int unsigned B_UDF    = 1;
  localparam int unsigned B_TXE    = 0;
  localparam int unsigned USED_W   = 15;

  typedef enum logic [GC_W-1:0] {
    GC_NONE     = 2'b00,
    GC_RST_PROG = 2'b01,
    GC_PROG     = 2'b10,
    GC_ALT_ID   = 2'b11
  } gc_kind_t;

endpackage

// File: rtl/sts_sticky.sv
module sts_sticky #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o,
  output logic nxt_o
);

  always_comb begin
    if (set_i)      nxt_o = 1'b1;
    else if (clr_i) nxt_o = 1'b0;
    else            nxt_o = q_o;
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= RST_VAL;
    else     q_o <= nxt_o;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o); // R12
  AST_CLR_APPLIES: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q_o); // R12

endmodule

// File: rtl/sts_tx_empty.sv
module sts_tx_empty #(
  parameter int unsigned WRITES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic wr_i,
  output logic q_o
);

  localparam int unsigned CW = (WRITES < 2) ? 1 : $clog2(WRITES + 1);
  localparam logic [CW-1:0] LAST = CW'(WRITES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_o   <= 1'b1;
      cnt_q <= '0;
    end else if (set_i) begin
      q_o   <= 1'b1;
      cnt_q <= '0;
    end else if (q_o && wr_i) begin
      if (cnt_q == LAST) begin
        q_o   <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_TXE_SET: assert property (@(posedge clk) disable iff (rst)
    set_i |=> (q_o && cnt_q == '0)); // R11
  AST_TXE_EARLY_WR: assert property (@(posedge clk) disable iff (rst)
    (q_o && !set_i && wr_i && cnt_q != LAST) |=> q_o); // R11
  AST_TXE_LAST_WR: assert property (@(posedge clk) disable iff (rst)
    (q_o && !set_i && wr_i && cnt_q == LAST) |=> !q_o); // R11

endmodule

// File: rtl/sts_gc_rec.sv
module sts_gc_rec
  import i2c_tgt_status_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     gc_i,
  input  gc_kind_t kind_i,
  input  logic     clr_i,
  output gc_kind_t kind_o,
  output logic     any_o,
  output logic     any_nxt_o
);

  always_comb begin
    if (gc_i)       any_nxt_o = 1'b1;
    else if (clr_i) any_nxt_o = 1'b0;
    else            any_nxt_o = any_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_o <= GC_NONE;
      any_o  <= 1'b0;
    end else begin
      any_o <= any_nxt_o;
      if (gc_i)       kind_o <= kind_i;
      else if (clr_i) kind_o <= GC_NONE;
    end
  end

  AST_GC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !gc_i) |=> (!any_o && kind_o == GC_NONE)); // R6
  AST_GC_RECORD: assert property (@(posedge clk) disable iff (rst)
    gc_i |=> (any_o && kind_o == $past(kind_i))); // R6

endmodule

// File: rtl/i2c_tgt_status.sv
module i2c_tgt_status
  import i2c_tgt_status_pkg::*;
#(
  parameter int unsigned STS_W      = 32,
  parameter int unsigned TXE_WRITES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_start_match,
  input  logic             ev_rstart_match,
  input  logic [1:0]       ev_match_idx,
  input  logic             ev_stop,
  input  logic             ev_gc,
  input  logic [1:0]       ev_gc_kind,
  input  logic             cfg_gc_clr,
  input  logic             eng_busy,
  input  logic             ev_rd_nodata,
  input  logic             ev_rx_ovf,
  input  logic             ev_rx_byte,
  input  logic             rx_data_rd,
  input  logic             rx_flush,
  input  logic             ev_tx_done,
  input  logic             ev_tx_udf,
  input  logic             ev_tx_empty,
  input  logic             tx_data_wr,
  input  logic             sts_rd,
  output logic [STS_W-1:0] sts_rdata,
  output logic             irq
);

  // Sticky flag slots
  localparam int unsigned NSTK     = 8;
  localparam int unsigned K_START  = 0;
  localparam int unsigned K_RSTART = 1;
  localparam int unsigned K_STOPI  = 2;
  localparam int unsigned K_NODATA = 3;
  localparam int unsigned K_OVF    = 4;
  localparam int unsigned K_RXB    = 5;
  localparam int unsigned K_TXD    = 6;
  localparam int unsigned K_UDF    = 7;
  localparam logic [NSTK-1:0] STK_IRQ_MASK = 8'b1111_1100;
  localparam logic [STS_W-1:0] RST_WORD = STS_W'(1);

  gc_kind_t          gc_kind_in;
  gc_kind_t          gc_kind_q;
  logic              gc_any_q;
  logic              gc_any_nxt;
  logic              gc_rst;
  logic              any_match;
  logic              addr_q;
  logic [IDX_W-1:0]  idx_q;
  logic              busy_q;
  logic              txe_q;
  logic [NSTK-1:0]   set_v;
  logic [NSTK-1:0]   clr_v;
  logic [NSTK-1:0]   stk_q;
  logic [NSTK-1:0]   stk_nxt;
  logic [STS_W-1:0]  sts_word;

  assign gc_kind_in = gc_kind_t'(ev_gc_kind);
  assign gc_rst     = ev_gc && (gc_kind_in == GC_RST_PROG);
  assign any_match  = ev_start_match || ev_rstart_match;

  // Addressed-since-START tracker feeding the stop flag
  always_ff @(posedge clk) begin
    if (rst)                     addr_q <= 1'b0;
    else if (any_match)          addr_q <= 1'b1;
    else if (ev_stop || gc_rst)  addr_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)            idx_q <= '0;
    else if (any_match) idx_q <= ev_match_idx;
    else if (gc_rst)    idx_q <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= eng_busy;
  end

  // Set and clear triggers of each sticky flag
  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[K_START]  = ev_start_match;
    set_v[K_RSTART] = ev_rstart_match;
    set_v[K_STOPI]  = ev_stop && addr_q;
    set_v[K_NODATA] = ev_rd_nodata;
    set_v[K_OVF]    = ev_rx_ovf;
    set_v[K_RXB]    = ev_rx_byte;
    set_v[K_TXD]    = ev_tx_done;
    set_v[K_UDF]    = ev_tx_udf;
    clr_v[K_START]  = ev_stop || sts_rd || gc_rst;
    clr_v[K_RSTART] = ev_stop || sts_rd || gc_rst;
    clr_v[K_STOPI]  = sts_rd || gc_rst;
    clr_v[K_NODATA] = sts_rd || gc_rst;
    clr_v[K_OVF]    = rx_data_rd || gc_rst;
    clr_v[K_RXB]    = rx_data_rd || rx_flush || gc_rst;
    clr_v[K_TXD]    = tx_data_wr || gc_rst;
    clr_v[K_UDF]    = tx_data_wr || gc_rst;
  end

  for (genvar g = 0; g < NSTK; g++) begin : g_flag
    sts_sticky #(.RST_VAL(1'b0)) u_flag (
      .clk   (clk),
      .rst   (rst),
      .set_i (set_v[g]),
      .clr_i (clr_v[g]),
      .q_o   (stk_q[g]),
      .nxt_o (stk_nxt[g])
    );
  end

  sts_tx_empty #(.WRITES(TXE_WRITES)) u_txe (
    .clk   (clk),
    .rst   (rst),
    .set_i (ev_tx_empty || gc_rst),
    .wr_i  (tx_data_wr),
    .q_o   (txe_q)
  );

  sts_gc_rec u_gc (
    .clk       (clk),
    .rst       (rst),
    .gc_i      (ev_gc),
    .kind_i    (gc_kind_in),
    .clr_i     (cfg_gc_clr),
    .kind_o    (gc_kind_q),
    .any_o     (gc_any_q),
    .any_nxt_o (gc_any_nxt)
  );

  // Word assembly; upper bits stay zero
  always_comb begin
    sts_word = '0;
    sts_word[B_START]               = stk_q[K_START];
    sts_word[B_RSTART]              = stk_q[K_RSTART];
    sts_word[B_IDX_LO +: IDX_W]     = idx_q;
    sts_word[B_STOPI]               = stk_q[K_STOPI];
    sts_word[B_GC_LO +: GC_W]       = gc_kind_q;
    sts_word[B_GC_ANY]              = gc_any_q;
    sts_word[B_BUSY]                = busy_q;
    sts_word[B_NODATA]              = stk_q[K_NODATA];
    sts_word[B_OVF]                 = stk_q[K_OVF];
    sts_word[B_RXB]                 = stk_q[K_RXB];
    sts_word[B_TXD]                 = stk_q[K_TXD];
    sts_word[B_UDF]                 = stk_q[K_UDF];
    sts_word[B_TXE]                 = txe_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_rdata <= RST_WORD;
      irq       <= 1'b0;
    end else begin
      if (sts_rd) sts_rdata <= sts_word;
      irq <= (|(stk_nxt & STK_IRQ_MASK)) || gc_any_nxt;
    end
  end

  AST_STOP_AFTER_MATCH: assert property (@(posedge clk) disable iff (rst)
    (ev_stop && addr_q) |=> sts_word[B_STOPI]); // R5
  AST_GCRST_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    (gc_rst && !any_match) |=> (sts_word[B_TXE] && sts_word[B_IDX_LO +: IDX_W] == '0)); // R6
  AST_BUSY_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    eng_busy |=> sts_word[B_BUSY]); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (sts_word[B_STOPI +: 1] == 1'b0 && !gc_any_q && sts_word[B_NODATA:B_UDF] == '0) |-> !irq); // R13

endmodule

// File: tb/tb_i2c_tgt_status.sv
module tb_i2c_tgt_status;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_start_match, ev_rstart_match, ev_stop, ev_gc, cfg_gc_clr;
  logic [1:0]  ev_match_idx, ev_gc_kind;
  logic        eng_busy, ev_rd_nodata, ev_rx_ovf, ev_rx_byte, rx_data_rd, rx_flush;
  logic        ev_tx_done, ev_tx_udf, ev_tx_empty, tx_data_wr, sts_rd;
  logic [31:0] sts_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  i2c_tgt_status dut (
    .clk(clk), .rst(rst),
    .ev_start_match(ev_start_match), .ev_rstart_match(ev_rstart_match),
    .ev_match_idx(ev_match_idx), .ev_stop(ev_stop), .ev_gc(ev_gc),
    .ev_gc_kind(ev_gc_kind), .cfg_gc_clr(cfg_gc_clr), .eng_busy(eng_busy),
    .ev_rd_nodata(ev_rd_nodata), .ev_rx_ovf(ev_rx_ovf), .ev_rx_byte(ev_rx_byte),
    .rx_data_rd(rx_data_rd), .rx_flush(rx_flush), .ev_tx_done(ev_tx_done),
    .ev_tx_udf(ev_tx_udf), .ev_tx_empty(ev_tx_empty), .tx_data_wr(tx_data_wr),
    .sts_rd(sts_rd), .sts_rdata(sts_rdata), .irq(irq)
  );

  // Stimulus vector fields
  localparam logic [20:0] S_ST    = 21'd1 << 1;
  localparam logic [20:0] S_RSTM  = 21'd1 << 2;
  localparam logic [20:0] S_STOP  = 21'd1 << 5;
  localparam logic [20:0] S_GC    = 21'd1 << 6;
  localparam logic [20:0] S_GCCLR = 21'd1 << 9;
  localparam logic [20:0] S_BUSY  = 21'd1 << 10;
  localparam logic [20:0] S_NOD   = 21'd1 << 11;
  localparam logic [20:0] S_OVF   = 21'd1 << 12;
  localparam logic [20:0] S_RXB   = 21'd1 << 13;
  localparam logic [20:0] S_RXRD  = 21'd1 << 14;
  localparam logic [20:0] S_FLUSH = 21'd1 << 15;
  localparam logic [20:0] S_TXD   = 21'd1 << 16;
  localparam logic [20:0] S_UDF   = 21'd1 << 17;
  localparam logic [20:0] S_TXE   = 21'd1 << 18;
  localparam logic [20:0] S_TXWR  = 21'd1 << 19;
  localparam logic [20:0] S_SRD   = 21'd1 << 20;

  function automatic logic [20:0] idx(input logic [1:0] v);
    return 21'(v) << 3;
  endfunction
  function automatic logic [20:0] gck(input logic [1:0] v);
    return 21'(v) << 7;
  endfunction

  localparam int NV = 12;
  // Expected: [15] irq after the cycle, [14:0] read data when the vector reads
  localparam logic [20:0] STIM [NV] = '{
    S_ST | (21'd2 << 3), S_SRD, S_STOP, S_SRD,
    S_RXB | S_BUSY, S_OVF | S_SRD, S_FLUSH, S_RXRD | S_SRD,
    S_NOD | S_TXD | S_UDF, S_TXWR | S_SRD, S_TXWR | S_SRD, S_SRD
  };
  localparam logic [15:0] EXPV [NV] = '{
    16'h0000, 16'h5001, 16'h8000, 16'h1401,
    16'h8000, 16'h9049, 16'h8000, 16'h1011,
    16'h8000, 16'h1027, 16'h1001, 16'h1000
  };
  localparam string VREQ [NV] = '{
    "R3/R4", "R3/R2", "R5", "R5/R2",
    "R9/R7", "R9/R7", "R9", "R9",
    "R8/R10", "R10/R11", "R11", "R11"
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step(input logic [20:0] v);
    @(negedge clk);
    ev_start_match  = v[1];
    ev_rstart_match = v[2];
    ev_match_idx    = v[4:3];
    ev_stop         = v[5];
    ev_gc           = v[6];
    ev_gc_kind      = v[8:7];
    cfg_gc_clr      = v[9];
    eng_busy        = v[10];
    ev_rd_nodata    = v[11];
    ev_rx_ovf       = v[12];
    ev_rx_byte      = v[13];
    rx_data_rd      = v[14];
    rx_flush        = v[15];
    ev_tx_done      = v[16];
    ev_tx_udf       = v[17];
    ev_tx_empty     = v[18];
    tx_data_wr      = v[19];
    sts_rd          = v[20];
    @(posedge clk);
    #2;
  endtask

  task automatic rd(input string req, input logic [31:0] exp);
    step(S_SRD);
    check(req, sts_rdata, exp);
  endtask

  initial begin
    step(21'd0);
    step(21'd0);
    rst = 1'b0;
    check("R1 reset rdata", sts_rdata, 32'h1);
    check("R1 reset irq", {31'd0, irq}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      step(STIM[i]);
      check({VREQ[i], " irq"}, {31'd0, irq}, {31'd0, EXPV[i][15]});
      if (STIM[i][20]) check({VREQ[i], " rdata"}, sts_rdata, {17'd0, EXPV[i][14:0]});
    end

    // R3 R4: repeated START with slot 3
    step(S_RSTM | idx(2'd3));
    rd("R3 R4 rstart", 32'h3800);
    // R12: set and read in one cycle, the set survives
    step(S_NOD | S_SRD);
    check("R12 read before set", sts_rdata, 32'h1800);
    check("R12 irq", {31'd0, irq}, 32'd1);
    rd("R12 set kept", 32'h1820);
    check("R8 read clears", {31'd0, irq}, 32'd0);
    // R5: STOP after match, then STOP without match
    step(S_STOP);
    rd("R5 stop after match", 32'h1C00);
    step(S_STOP);
    rd("R5 stop no match", 32'h1800);
    // R6: program-address general call
    step(S_GC | gck(2'd2));
    check("R13 irq gc", {31'd0, irq}, 32'd1);
    rd("R6 gc program", 32'h1A80);
    // R6: general-call reset restores defaults
    step(S_ST | idx(2'd1));
    step(S_TXD | S_OVF);
    rd("R6 before gc reset", 32'h4A94);
    step(S_GC | gck(2'd1));
    rd("R6 gc reset", 32'h0181);
    step(S_STOP);
    check("R2 rdata held", sts_rdata, 32'h0181);
    rd("R5 no stop flag after gc reset", 32'h0181);
    step(S_GCCLR);
    check("R13 irq after gc clr", {31'd0, irq}, 32'd0);
    rd("R6 gc clr", 32'h0001);
    step(S_GC | gck(2'd3) | S_GCCLR);
    rd("R12 gc set wins", 32'h0381);
    step(S_GCCLR);
    rd("R6 gc clr again", 32'h0001);
    // R11: two-write clear and restart
    step(S_TXWR);
    rd("R11 one write keeps", 32'h0001);
    step(S_TXE);
    step(S_TXWR);
    rd("R11 restart keeps", 32'h0001);
    step(S_TXWR | S_TXE);
    step(S_TXWR);
    rd("R11 set wins over write", 32'h0001);
    step(S_TXWR);
    rd("R11 second write clears", 32'h0000);
    // R7 R13: busy follows engine, no interrupt
    step(S_BUSY);
    check("R13 busy no irq", {31'd0, irq}, 32'd0);
    step(S_BUSY | S_SRD);
    check("R7 busy bit", sts_rdata, 32'h0040);
    rd("R7 busy snapshot", 32'h0040);
    rd("R7 busy dropped", 32'h0000);
    // R1: reset mid-run
    step(S_NOD);
    rst = 1'b1;
    step(21'd0);
    step(21'd0);
    rst = 1'b0;
    check("R1 rdata after reset", sts_rdata, 32'h1);
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd("R1 word after reset", 32'h0000_0001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule